// File: doc/BRIEF.md
# I2C Target with Four Masked Addresses

This block is an I2C target (slave) that runs entirely on the system clock. It oversamples SCL and SDA through a synchronizer and finds START, repeated START and STOP conditions from edges of the synchronized lines. It then shifts in a 7-bit address and an R/W bit. That address is compared against four programmable address slots. Each slot has its own enable and a per-bit mask, and a mask bit of 1 makes that address bit a don't-care.

On a match the target acknowledges and then moves bytes. For a write, each received byte appears on a one-cycle strobe. For a read, the target loads a byte from the user side at the start of each byte and pulses a request so the user can present the next one. SDA is open drain: the block only ever pulls the line low.

A watchdog counts system clocks while SCL is held low during a transfer. On terminal count it drops SDA, forces the state machine to idle and pulses a flag.

The controller lives in one state machine with these states:
- `ST_IDLE`: bus not addressed.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE`: receiving a data byte.
- `ST_WR_ACK`: acknowledging a received byte.
- `ST_RD_BYTE`: sending a data byte.
- `ST_RD_ACK`: sampling the controller's acknowledge.
- `ST_IGNORE`: not addressed, or the controller answered NACK.

The transitions are:
- STOP, from any state, goes to idle.
- Watchdog expiry, from any state, goes to idle.
- START, from any state, goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match, or to `ST_IGNORE` on a miss. This happens on the SCL fall after the 8th bit.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE` according to R/W.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on ACK, or to `ST_IGNORE` on NACK.

Top module: `i2c_tgt_masked`

## Requirements
- R1: A START (SDA falls while SCL is high) begins the address phase from any state. A STOP (SDA rises while SCL is high) returns the target to idle with SDA released, so data clocked after a STOP and before the next START gets no acknowledge and no strobe.
- R2: The address byte is sampled on SCL rising edges, MSB first: bits 7..1 are the address and bit 0 is R/W (1 = read). On a match the target pulls SDA low for the whole 9th SCL pulse.
- R3: Slot i matches when slot_en[i] is 1 and ((addr XOR slot_addr[i]) AND NOT slot_mask[i]) is zero. Slot i occupies bits [7*i+6 : 7*i] of slot_addr and of slot_mask.
- R4: On a match, match_valid pulses for one cycle together with match_rw and match_slot. match_slot is the lowest-numbered matching slot.
- R5: On no match the target leaves the address acknowledge high. Until the next START or STOP it drives nothing, raises no rx_valid and acknowledges no byte.
- R6: In a write, each byte is shifted in MSB first and presented on rx_data with a one-cycle rx_valid pulse. Every byte is acknowledged by pulling SDA low on its 9th pulse.
- R7: In a read, tx_data is loaded when each byte starts, with a one-cycle tx_req pulse, and sent MSB first. SDA changes only while SCL is low.
- R8: If the controller answers a read byte with NACK (SDA high on the 9th pulse), the target loads no further byte and keeps SDA released until START or STOP.
- R9: A repeated START after any acknowledge slot restarts the address phase, and the new address and direction are used.
- R10: While a transfer is active and SCL stays low, a 14-bit counter runs. After 2^14−1 clocks it pulses timeout_pulse for one cycle, releases SDA and returns to idle. A new START is then served normally.
- R11: After reset, sda_oe, rx_valid, tx_req, match_valid and timeout_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| slot_addr | input | 28 | Four 7-bit target addresses, slot i at [7i+6:7i] |
| slot_mask | input | 28 | Four 7-bit masks, 1 = don't-care bit |
| slot_en | input | 4 | Per-slot enable |
| rx_data | output | 8 | Last byte received in a write |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_data | input | 8 | Byte to send in a read |
| tx_req | output | 1 | One-cycle pulse: tx_data was taken |
| match_valid | output | 1 | One-cycle pulse on address match |
| match_slot | output | 2 | Index of the matching slot |
| match_rw | output | 1 | R/W bit of the matched address |
| timeout_pulse | output | 1 | One-cycle pulse when the SCL-low watchdog expires |

## Verification
The bench aims at the overlap of slot 1 (masked range 0x20–0x23) and slot 2 (0x21). It also targets a disabled slot, an address that differs only in an unmasked bit, and a read that ends on NACK. A wrong priority encoder would report slot 2 for 0x21. A wrong mask polarity would acknowledge 0x24 or miss 0x22. A target that ignored the NACK would keep driving data into the bit after it.

A repeated START between a write and a read checks that the address phase really restarts. A design that missed it would take the second address byte as data. The timeout is sampled just before and just after 2^14−1 held-low clocks, which catches an off-by-a-lot terminal count and an SDA that stays pulled after expiry. Data clocked after a STOP must go unanswered, which catches a STOP that fails to return the target to idle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL/SDA and derives edge and bus-condition events.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Idle bus is high, so reset everything to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_addr_match.sv
// Masked comparison against all slots with a lowest-index priority pick.
module i2c_addr_match #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_mask,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    output logic                        hit_any,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [NUM_SLOTS-1:0] below_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [ADDR_W-1:0] diff;
        assign diff       = (addr ^ slot_addr[g*ADDR_W +: ADDR_W]) & ~slot_mask[g*ADDR_W +: ADDR_W];
        assign hit_vec[g] = slot_en[g] & (diff == '0);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit_any   = |hit_vec;
        below_idx = (NUM_SLOTS'(1) << hit_idx) - NUM_SLOTS'(1);
        if (hit_any) begin
            AST_PICKED_SLOT_HITS: assert (hit_vec[hit_idx]); // R4
            AST_NO_LOWER_HIT: assert ((hit_vec & below_idx) == '0); // R4
        end
    end

endmodule

// File: rtl/i2c_bus_watchdog.sv
// Counts clocks with SCL held low during an active transfer.
module i2c_bus_watchdog #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_s,
    input  logic scl_edge,
    output logic timeout
);
    localparam logic [CNT_W-1:0] TERM = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (!active || scl_edge || scl_s) begin
                cnt <= '0;
            end else if (cnt == TERM) begin
                cnt     <= '0;
                timeout <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TO_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R10

    AST_TO_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(!scl_s)); // R10

endmodule

// File: rtl/i2c_tgt_masked.sv
module i2c_tgt_masked
    import i2c_tgt_pkg::*;
#(
    parameter int N_SLOTS     = NUM_SLOTS,
    parameter int A_W         = ADDR_W,
    parameter int TO_BITS     = 14,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [N_SLOTS*A_W-1:0]   slot_addr,
    input  logic [N_SLOTS*A_W-1:0]   slot_mask,
    input  logic [N_SLOTS-1:0]       slot_en,
    output logic [BYTE_W-1:0]        rx_data,
    output logic                     rx_valid,
    input  logic [BYTE_W-1:0]        tx_data,
    output logic                     tx_req,
    output logic                     match_valid,
    output logic [IDX_W-1:0]         match_slot,
    output logic                     match_rw,
    output logic                     timeout_pulse
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    tgt_state_e state_q, state_d;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sh_rx;
    logic [BYTE_W-1:0] sh_tx;
    logic              rw_q;
    logic              host_ack;
    logic              byte_end;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_match #(.NUM_SLOTS(N_SLOTS), .ADDR_W(A_W)) u_match (
        .addr      (sh_rx[BYTE_W-1:1]),
        .slot_addr (slot_addr),
        .slot_mask (slot_mask),
        .slot_en   (slot_en),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx)
    );

    i2c_bus_watchdog #(.CNT_W(TO_BITS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state_q != ST_IDLE),
        .scl_s    (scl_s),
        .scl_edge (scl_rise | scl_fall),
        .timeout  (timeout_pulse)
    );

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic; bus conditions and the watchdog take precedence.
    always_comb begin
        state_d = state_q;
        if (timeout_pulse || stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = hit_any ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = host_ack ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Shift registers, bit counter and user-side strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            sh_rx       <= '0;
            sh_tx       <= '1;
            rw_q        <= 1'b0;
            host_ack    <= 1'b0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            tx_req      <= 1'b0;
            match_valid <= 1'b0;
            match_slot  <= '0;
            match_rw    <= 1'b0;
        end else begin
            rx_valid    <= 1'b0;
            tx_req      <= 1'b0;
            match_valid <= 1'b0;
            if (timeout_pulse || stop_det || start_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            sh_rx   <= {sh_rx[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            if (state_q == ST_ADDR) begin
                                rw_q <= sh_rx[0];
                                if (hit_any) begin
                                    match_valid <= 1'b1;
                                    match_slot  <= hit_idx;
                                    match_rw    <= sh_rx[0];
                                end
                            end else begin
                                rx_data  <= sh_rx;
                                rx_valid <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                sh_tx  <= tx_data;
                                tx_req <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall && bit_cnt != LAST_BIT)
                            sh_tx <= {sh_tx[BYTE_W-2:0], 1'b1};
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) host_ack <= ~sda_s;
                        if (scl_fall && host_ack) begin
                            sh_tx   <= tx_data;
                            tx_req  <= 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain output decode
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~sh_tx[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R7

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state_q == ST_IDLE)); // R1

    AST_RX_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> (state_q == ST_IDLE && !sda_oe)); // R10

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (!rx_valid && !tx_req && !match_valid)); // R5

endmodule

// File: tb/sim_i2c_tgt_masked.sv
module sim_i2c_tgt_masked;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        ctl_pull = 1'b0;
    logic        sda_oe;
    logic [27:0] slot_addr;
    logic [27:0] slot_mask;
    logic [3:0]  slot_en;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic [7:0]  tx_data;
    logic        tx_req;
    logic        match_valid;
    logic [1:0]  match_slot;
    logic        match_rw;
    logic        timeout_pulse;
    logic        sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int rx_n = 0, match_n = 0, to_n = 0, tx_i = 0;
    logic [7:0] rx_log [0:31];
    logic [1:0] last_slot;
    logic       last_rw;
    bit         done = 0;

    always #5 clk = ~clk;

    assign sda_line = ~(ctl_pull | sda_oe);

    i2c_tgt_masked u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .slot_addr     (slot_addr),
        .slot_mask     (slot_mask),
        .slot_en       (slot_en),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .tx_data       (tx_data),
        .tx_req        (tx_req),
        .match_valid   (match_valid),
        .match_slot    (match_slot),
        .match_rw      (match_rw),
        .timeout_pulse (timeout_pulse)
    );

    function automatic logic [7:0] tx_pat(int k);
        return 8'hC3 + 8'(k * 37);
    endfunction

    // Observation of user-side strobes, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rx_log[rx_n % 32] = rx_data;
                rx_n++;
            end
            if (match_valid) begin
                last_slot = match_slot;
                last_rw   = match_rw;
                match_n++;
            end
            if (timeout_pulse) to_n++;
            if (tx_req) begin
                tx_i++;
                tx_data = tx_pat(tx_i);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        ctl_pull = ~b; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        ctl_pull = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_start();
        ctl_pull = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        ctl_pull = 1'b1; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        ctl_pull = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        ctl_pull = 1'b0; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic t_reset();
        chk("R11 sda_oe", sda_oe, 0);
        chk("R11 rx_valid", rx_valid, 0);
        chk("R11 tx_req", tx_req, 0);
        chk("R11 match_valid", match_valid, 0);
        chk("R11 timeout", timeout_pulse, 0);
    endtask

    task automatic t_write();
        logic ack;
        int m0 = match_n, r0 = rx_n;
        bus_start();
        write_byte({7'h50, 1'b0}, ack);
        chk("R2 address ack", ack, 1);
        chk("R4 match count", match_n - m0, 1);
        chk("R4 slot", last_slot, 0);
        chk("R4 rw", last_rw, 0);
        write_byte(8'hA5, ack);
        chk("R6 ack byte0", ack, 1);
        write_byte(8'h3C, ack);
        chk("R6 ack byte1", ack, 1);
        chk("R6 rx count", rx_n - r0, 2);
        chk("R6 rx byte0", rx_log[r0 % 32], 8'hA5);
        chk("R6 rx byte1", rx_log[(r0 + 1) % 32], 8'h3C);
        bus_stop();
        chk("R1 released after stop", sda_oe, 0);
        write_byte(8'h81, ack);
        chk("R1 no ack after stop", ack, 0);
        chk("R1 no rx after stop", rx_n - r0, 2);
    endtask

    task automatic t_mask();
        logic ack;
        int m0 = match_n;
        bus_start();
        write_byte({7'h22, 1'b0}, ack);
        chk("R3 masked match ack", ack, 1);
        chk("R3 masked slot", last_slot, 1);
        bus_stop();
        bus_start();
        write_byte({7'h21, 1'b0}, ack);
        chk("R4 overlap ack", ack, 1);
        chk("R4 lowest slot wins", last_slot, 1);
        bus_stop();
        bus_start();
        write_byte({7'h24, 1'b0}, ack);
        chk("R3 unmasked bit differs", ack, 0);
        bus_stop();
        chk("R3 match count", match_n - m0, 2);
    endtask

    task automatic t_disabled();
        logic ack;
        int m0 = match_n, r0 = rx_n;
        bus_start();
        write_byte({7'h70, 1'b0}, ack);
        chk("R5 disabled slot nack", ack, 0);
        write_byte(8'h11, ack);
        chk("R5 data not acked", ack, 0);
        chk("R5 no rx strobe", rx_n - r0, 0);
        chk("R5 no match", match_n - m0, 0);
        bus_stop();
    endtask

    task automatic t_read();
        logic ack, b;
        logic [7:0] d;
        int base = tx_i;
        bus_start();
        write_byte({7'h50, 1'b1}, ack);
        chk("R2 read address ack", ack, 1);
        chk("R4 read rw", last_rw, 1);
        read_byte(d, 1'b0);
        chk("R7 first read byte", d, tx_pat(base));
        read_byte(d, 1'b1);
        chk("R7 second read byte", d, tx_pat(base + 1));
        get_bit(b);
        chk("R8 line released after nack", b, 1);
        chk("R8 sda_oe after nack", sda_oe, 0);
        chk("R8 loads only two", tx_i - base, 2);
        bus_stop();
    endtask

    task automatic t_rstart();
        logic ack;
        logic [7:0] d;
        int r0 = rx_n;
        bus_start();
        write_byte({7'h50, 1'b0}, ack);
        write_byte(8'h77, ack);
        chk("R9 pre-restart rx", rx_log[r0 % 32], 8'h77);
        bus_start();
        write_byte({7'h23, 1'b1}, ack);
        chk("R9 restart address ack", ack, 1);
        chk("R9 restart slot", last_slot, 1);
        chk("R9 restart rw", last_rw, 1);
        read_byte(d, 1'b1);
        chk("R9 restart read data", d, tx_pat(tx_i - 1));
        chk("R9 address not taken as data", rx_n - r0, 1);
        bus_stop();
    endtask

    task automatic t_timeout();
        logic ack;
        int t0 = to_n;
        bus_start();
        for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b0 : (7'h50 >> (i - 1)) & 1'b1);
        repeat (16300) @(negedge clk);
        chk("R10 no early timeout", to_n - t0, 0);
        chk("R10 still acking before expiry", sda_oe, 1);
        repeat (200) @(negedge clk);
        chk("R10 timeout pulsed once", to_n - t0, 1);
        chk("R10 released after timeout", sda_oe, 0);
        bus_start();
        write_byte({7'h50, 1'b0}, ack);
        chk("R10 recovered ack", ack, 1);
        bus_stop();
    endtask

    initial begin
        slot_addr = {7'h70, 7'h21, 7'h20, 7'h50};
        slot_mask = {7'h00, 7'h00, 7'h03, 7'h00};
        slot_en   = 4'b0111;
        tx_data   = tx_pat(0);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_write();
        t_mask();
        t_disabled();
        t_read();
        t_rstart();
        t_timeout();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule